// File: doc/BRIEF.md
# Latch-up Supervision Controller

This block protects a single supply path against the runaway current of a latch-up event. A current-sense front end and converter, outside this block, deliver digitised load-current samples with a valid strobe. The block compares each valid sample against a programmable limit. If enough consecutive valid samples lie strictly above that limit, it trips. It then disconnects the load by driving the isolation switch enable. At the same time it drives a shunt switch enable that drains residual current away from the load so that the parasitic structure switches off.

The off period is measured in pulses of a slow timebase input, for example one pulse per millisecond for a hold of about 100 ms. The shunt is released one timebase pulse before the load is reconnected. After that, monitoring resumes without any outside action. Each trip sets a sticky interrupt for the supervising microcontroller, which clears it with a one-cycle pulse, and adds one to a saturating event counter. Each supply path uses its own instance of the block.

Top module: `lu_guard`

## Requirements
- R1: After synchronous reset, `iso_en`, `shunt_en` and `irq` are 0, `trip_cnt` is 0, and `limit_q` equals 2 × `NOM_CURRENT`.
- R2: When `lim_wr` is 1 at a clock edge, `lim_din` is stored as the limit. It is visible on `limit_q` after that edge and is used for every comparison from the next sample onward.
- R3: A trip occurs on the edge that captures the `CONSEC`-th (default 2) consecutive valid sample strictly greater than the limit. `iso_en` and `shunt_en` read 1 just after that edge. A sample equal to the limit does not count as over.
- R4: A valid sample at or below the limit restarts the run of over-limit samples, so a single over-limit sample never trips. Cycles with `sample_vld` low neither extend nor break the run.
- R5: While isolated, timebase pulses are counted. `shunt_en` falls on the edge of pulse `HOLD_TICKS`-1 and `iso_en` falls on the edge of pulse `HOLD_TICKS`, counted from the trip.
- R6: Samples that arrive during isolation are ignored. They do not extend the hold and do not add trips. On release the run history is empty, so `CONSEC` new over-limit samples are needed for the next trip.
- R7: `irq` becomes 1 on the trip edge and stays 1 after power is restored, until an `irq_clr` pulse clears it. If a trip and `irq_clr` coincide, `irq` stays 1.
- R8: `trip_cnt` increases by one on each trip and saturates at 255. It does not wrap.
- R9: Timebase pulses while monitoring have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse used to count the hold |
| sample_vld | input | 1 | Current sample strobe |
| sample | input | SAMPLE_W | Digitised load current |
| lim_wr | input | 1 | Limit register write strobe |
| lim_din | input | SAMPLE_W | New limit value |
| irq_clr | input | 1 | Interrupt clear pulse |
| iso_en | output | 1 | 1 = load disconnected from supply |
| shunt_en | output | 1 | 1 = residual-current shunt closed |
| irq | output | 1 | Sticky trip interrupt |
| trip_cnt | output | CNT_W | Saturating trip counter |
| limit_q | output | SAMPLE_W | Current limit register value |

## Verification
The hardest state to reach is the saturated counter. Getting there takes 255 complete trip-and-release cycles. The bench therefore sets a short hold and loops a task that trips the block with two over-limit samples and then issues the hold's timebase pulses. A second hard case is a trip and an interrupt clear in the same cycle. This case is set up by holding the strobe, sample and clear together across a single edge, directly after a lone over-limit sample has armed the run.

// File: rtl/lu_guard_pkg.sv
package lu_guard_pkg;

  typedef enum logic [1:0] {
    ST_WATCH   = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_ISOLATE = 2'd2
  } lu_state_e;

endpackage

// File: rtl/lu_trip_filter.sv
module lu_trip_filter #(
  parameter int SAMPLE_W = 12,
  parameter int CONSEC   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                armed,
  input  logic                sample_vld,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] limit,
  output logic                trip
);

  localparam int RUN_W = (CONSEC > 1) ? $clog2(CONSEC) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CONSEC - 1);

  logic             over;
  logic [RUN_W-1:0] run_q;

  assign over = sample > limit;
  assign trip = armed && sample_vld && over && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      run_q <= '0;
    end else if (sample_vld) begin
      if (!over)
        run_q <= '0;
      else if (run_q != RUN_LAST)
        run_q <= run_q + 1'b1;
    end
  end

  // R4: a sample at or below the limit empties the run
  p_run_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && sample_vld && !over) |=> (run_q == '0));

endmodule

// File: rtl/lu_hold_fsm.sv
module lu_hold_fsm
  import lu_guard_pkg::*;
#(
  parameter int HOLD_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trip,
  output logic armed,
  output logic iso_en,
  output logic shunt_en
);

  localparam int HOLD_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [HOLD_W-1:0] LAST_DRAIN = HOLD_W'(HOLD_TICKS - 2);

  lu_state_e        state_q;
  logic [HOLD_W-1:0] tcnt_q;
  logic             iso_q;
  logic             shunt_q;

  assign armed    = (state_q == ST_WATCH);
  assign iso_en   = iso_q;
  assign shunt_en = shunt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WATCH;
      tcnt_q  <= '0;
      iso_q   <= 1'b0;
      shunt_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WATCH: begin
          if (trip) begin
            state_q <= ST_DRAIN;
            tcnt_q  <= '0;
            iso_q   <= 1'b1;
            shunt_q <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == LAST_DRAIN) begin
              state_q <= ST_ISOLATE;
              shunt_q <= 1'b0;
            end
          end
        end
        ST_ISOLATE: begin
          if (tick) begin
            state_q <= ST_WATCH;
            tcnt_q  <= '0;
            iso_q   <= 1'b0;
          end
        end
        default: begin
          state_q <= ST_WATCH;
          iso_q   <= 1'b0;
          shunt_q <= 1'b0;
        end
      endcase
    end
  end

  // R5: the shunt is only ever closed while the load is isolated
  p_shunt_in_iso_r5: assert property (@(posedge clk) disable iff (rst)
    shunt_q |-> iso_q);

  // R5: reconnection never happens with the shunt still closed one cycle earlier
  p_release_order_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_q) |-> !$past(shunt_q));

  // R6: without a timebase pulse the hold cannot change
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!armed && !tick) |=> ($stable(iso_q) && $stable(shunt_q)));

endmodule

// File: rtl/lu_event_log.sv
module lu_event_log #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip,
  input  logic             irq_clr,
  output logic             irq,
  output logic [CNT_W-1:0] trip_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;

  assign irq      = irq_q;
  assign trip_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (trip)
        irq_q <= 1'b1;
      else if (irq_clr)
        irq_q <= 1'b0;
      if (trip && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: the interrupt holds until cleared
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr) |=> irq_q);

  // R8: the counter never wraps from its maximum
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R8: each trip below saturation adds exactly one
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (trip && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lu_guard.sv
module lu_guard #(
  parameter int SAMPLE_W    = 12,
  parameter int NOM_CURRENT = 500,
  parameter int HOLD_TICKS  = 100,
  parameter int CONSEC      = 2,
  parameter int CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                sample_vld,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                lim_wr,
  input  logic [SAMPLE_W-1:0] lim_din,
  input  logic                irq_clr,
  output logic                iso_en,
  output logic                shunt_en,
  output logic                irq,
  output logic [CNT_W-1:0]    trip_cnt,
  output logic [SAMPLE_W-1:0] limit_q
);

  localparam logic [SAMPLE_W-1:0] LIMIT_RST = SAMPLE_W'(2 * NOM_CURRENT);

  logic [SAMPLE_W-1:0] limit_r;
  logic                armed;
  logic                trip;

  assign limit_q = limit_r;

  always_ff @(posedge clk) begin
    if (rst)
      limit_r <= LIMIT_RST;
    else if (lim_wr)
      limit_r <= lim_din;
  end

  lu_trip_filter #(
    .SAMPLE_W (SAMPLE_W),
    .CONSEC   (CONSEC)
  ) u_filter (
    .clk        (clk),
    .rst        (rst),
    .armed      (armed),
    .sample_vld (sample_vld),
    .sample     (sample),
    .limit      (limit_r),
    .trip       (trip)
  );

  lu_hold_fsm #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .trip     (trip),
    .armed    (armed),
    .iso_en   (iso_en),
    .shunt_en (shunt_en)
  );

  lu_event_log #(
    .CNT_W (CNT_W)
  ) u_log (
    .clk      (clk),
    .rst      (rst),
    .trip     (trip),
    .irq_clr  (irq_clr),
    .irq      (irq),
    .trip_cnt (trip_cnt)
  );

  // R3: isolation only begins from a valid over-limit sample
  p_trip_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(iso_en) |-> ($past(sample_vld) && ($past(sample) > $past(limit_r))));

  // R7: every start of isolation leaves the interrupt raised
  p_irq_on_trip_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(iso_en) |-> irq);

endmodule

// File: tb/sim_lu_guard.sv
module sim_lu_guard;

  localparam int W    = 12;
  localparam int HOLD = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         sample_vld = 1'b0;
  logic [W-1:0] sample = '0;
  logic         lim_wr = 1'b0;
  logic [W-1:0] lim_din = '0;
  logic         irq_clr = 1'b0;
  logic         iso_en, shunt_en, irq;
  logic [7:0]   trip_cnt;
  logic [W-1:0] limit_q;

  int n_run  = 0;
  int n_fail = 0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  lu_guard #(
    .SAMPLE_W (W), .NOM_CURRENT (500), .HOLD_TICKS (HOLD),
    .CONSEC (2), .CNT_W (8)
  ) u0 (
    .clk (clk), .rst (rst), .tick (tick), .sample_vld (sample_vld),
    .sample (sample), .lim_wr (lim_wr), .lim_din (lim_din),
    .irq_clr (irq_clr), .iso_en (iso_en), .shunt_en (shunt_en),
    .irq (irq), .trip_cnt (trip_cnt), .limit_q (limit_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int v);
    @(negedge clk); sample_vld = 1'b1; sample = W'(v);
    @(negedge clk); sample_vld = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic release_hold();
    for (int i = 0; i < HOLD; i++) pulse_tick();
  endtask

  task automatic t_reset();
    chk("R1 iso_en", int'(iso_en), 0);
    chk("R1 shunt_en", int'(shunt_en), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 trip_cnt", int'(trip_cnt), 0);
    chk("R1 limit_q", int'(limit_q), 1000);
  endtask

  task automatic t_filter();
    send(1200);
    chk("R4 single over", int'(iso_en), 0);
    send(900); send(1200);
    chk("R4 run broken", int'(iso_en), 0);
    send(1000); send(1000);
    chk("R3 equal no trip", int'(iso_en), 0);
    send(1001);
    chk("R3 one over", int'(iso_en), 0);
    repeat (3) @(negedge clk);
    send(1001);
    exp_cnt++;
    chk("R3 iso on trip", int'(iso_en), 1);
    chk("R3 shunt on trip", int'(shunt_en), 1);
    chk("R7 irq on trip", int'(irq), 1);
    chk("R8 count", int'(trip_cnt), exp_cnt);
  endtask

  task automatic t_hold();
    pulse_tick();
    chk("R5 tick1 shunt", int'(shunt_en), 1);
    send(2000); send(2000);
    chk("R6 no retrip count", int'(trip_cnt), exp_cnt);
    pulse_tick();
    chk("R5 tick2 shunt", int'(shunt_en), 1);
    pulse_tick();
    chk("R5 tick3 shunt off", int'(shunt_en), 0);
    chk("R5 tick3 iso held", int'(iso_en), 1);
    pulse_tick();
    chk("R5 tick4 iso off", int'(iso_en), 0);
    chk("R6 hold not extended", int'(trip_cnt), exp_cnt);
    send(2000);
    chk("R6 history cleared", int'(iso_en), 0);
    send(2000);
    exp_cnt++;
    chk("R6 new trip", int'(iso_en), 1);
    release_hold();
  endtask

  task automatic t_irq_tick();
    chk("R7 irq sticky", int'(irq), 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R7 irq cleared", int'(irq), 0);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R9 tick iso", int'(iso_en), 0);
    chk("R9 tick shunt", int'(shunt_en), 0);
    chk("R9 tick count", int'(trip_cnt), exp_cnt);
  endtask

  task automatic t_limit();
    @(negedge clk); lim_wr = 1'b1; lim_din = W'(200);
    @(negedge clk); lim_wr = 1'b0;
    chk("R2 limit_q", int'(limit_q), 200);
    send(250); send(250);
    exp_cnt++;
    chk("R2 trip at new limit", int'(iso_en), 1);
    release_hold();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    send(250);
    @(negedge clk); sample_vld = 1'b1; sample = W'(250); irq_clr = 1'b1;
    @(negedge clk); sample_vld = 1'b0; irq_clr = 1'b0;
    exp_cnt++;
    chk("R7 set beats clear", int'(irq), 1);
    chk("R8 count", int'(trip_cnt), exp_cnt);
    release_hold();
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 260; k++) begin
      send(300); send(300);
      release_hold();
    end
    chk("R8 saturated", int'(trip_cnt), 255);
    send(300); send(300);
    chk("R8 stays at max", int'(trip_cnt), 255);
    release_hold();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_filter();
    t_hold();
    t_irq_tick();
    t_limit();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule